// File: doc/BRIEF.md
# Command/Response Buffer Controller

This block moves a command packet from a host into a shared byte buffer, hands it to an execution backend, and then streams the backend's answer back to the host. The host sees two registers. One is a byte-wide data port for FIFO traffic. The other is a status word that carries the transfer flags and a dynamic burst count. A five-state transfer machine moves through idle, ready, reception, execution and completion, and it decides which host actions take effect and which are dropped.

The end of a command is found from the packet itself. Once at least six bytes have arrived, bytes 2 through 5 form a big-endian 32-bit total length. The block keeps asking for data until that many bytes are in. While the machine is in execution, the backend owns the buffer through its own port. It rewrites the buffer with the response and reports the response length on a done strobe. Events for command-ready and data-available are pulsed for whatever interrupt logic sits outside.

Top module: `cmdrsp_buf_ctrl`

## Requirements
- R1: After synchronous reset the machine is idle and no event or backend strobe is raised. The status word then reads 0 in its flag byte, with the burst count (bits 31:8) equal to DEPTH.
- R2: The status flags sit at these positions: valid bit 7, command-ready bit 6, data-available bit 4, expect bit 3, self-test-done bit 2. A status write of exactly 0x40 (command-ready) acts as follows, depending on the state:
  - In idle it moves the machine to ready, sets command-ready and pulses ev_cmd_ready.
  - In ready it only clears both pointers.
  - In completion it clears both pointers, clears data-available, moves to ready, and sets command-ready with an event if that flag was clear.
- R3: The first FIFO write in ready moves the machine to reception, sets expect and valid, and stores the byte at offset 0. Later bytes are stored at consecutive offsets. FIFO writes in idle, execution or completion, or in reception with expect clear, are dropped.
- R4: Once more than 5 bytes are stored, bytes 2..5 are read as a big-endian length. Expect stays set while that length exceeds the bytes received. Expect clears, with valid set, once the packet is complete.
- R5: A status write of exactly 0x20 (go) in reception with expect clear enters execution and pulses exe_start, with exe_cmd_len holding the byte count. In every other case go is ignored.
- R6: exe_done in execution enters completion, sets valid and data-available, zeroes both pointers and pulses ev_data_avail.
- R7: A FIFO read in completion with data-available set returns the next response byte in bits 7:0. Any other FIFO read returns 0xFF. Reading the last byte leaves only valid set (plus self-test-done).
- R8: The burst count is the number of response bytes left while data-available is set, and DEPTH minus the bytes written otherwise. A status read with host_byte set saturates it at 0xFF.
- R9: A status write of exactly 0x02 (retry) in completion rewinds the read pointer and sets valid and data-available. In other states it is ignored.
- R10: Self-test-done is set by exe_selftest together with exe_done. Every status update keeps it, and only reset clears it.
- R11: Command-ready in reception aborts at once: the machine returns to ready with command-ready set and an event. In execution it pulses exe_cancel instead, and the next exe_done then returns the machine to ready with command-ready and an event, and with no response data.
- R12: A FIFO write past DEPTH bytes is discarded, and the flags are left as expect and valid.
- R13: A status write value other than exactly one of 0x40, 0x20 or 0x02 (after masking to those bits) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = status word, 1 = data FIFO |
| host_byte | input | 1 | Single-byte status read (saturates burst) |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Read data valid, one cycle after host_req |
| host_rdata | output | 32 | Read data |
| exe_start | output | 1 | Pulse: command ready for backend |
| exe_cancel | output | 1 | Pulse: backend asked to abort |
| exe_cmd_len | output | PW | Bytes in the stored command |
| exe_done | input | 1 | Backend finished |
| exe_resp_len | input | PW | Response length, with exe_done |
| exe_selftest | input | 1 | Self-test completed, with exe_done |
| be_en | input | 1 | Backend buffer access (execution only) |
| be_we | input | 1 | Backend buffer write |
| be_addr | input | AW | Backend buffer address |
| be_wdata | input | 8 | Backend write byte |
| be_rdata | output | 8 | Backend read byte, one cycle later |
| ev_cmd_ready | output | 1 | Pulse: command-ready raised |
| ev_data_avail | output | 1 | Pulse: response available |

## Verification
A wrong machine state first shows up in the cycle after the next host access. A status read then returns the wrong flag byte, a FIFO read returns 0xFF instead of data (or data instead of 0xFF), or go fails to produce exe_start. A wrong write or read pointer shows up in the burst count of the very next status read, and later in the bytes the backend reads back or the host streams out. A wrong length decode keeps expect set, or clears it, at the sixth byte or at the last one, so go is taken or refused one cycle later.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECEP = 3'd2,
    ST_EXEC  = 3'd3,
    ST_COMPL = 3'd4
  } cbc_state_e;

  localparam int B_VALID = 7;
  localparam int B_CRDY  = 6;
  localparam int B_DAV   = 4;
  localparam int B_EXP   = 3;
  localparam int B_STD   = 2;

  localparam logic [7:0] ACT_CRDY  = 8'h40;
  localparam logic [7:0] ACT_GO    = 8'h20;
  localparam logic [7:0] ACT_RETRY = 8'h02;
  localparam logic [7:0] ACT_MASK  = 8'h62;
endpackage

// File: rtl/cmdrsp_mem.sv
module cmdrsp_mem #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // single port, read-first, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cmdrsp_len_track.sv
module cmdrsp_len_track #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [PW-1:0] wptr,
  input  logic [7:0]    wdata,
  output logic [31:0]   len_next
);
  logic [31:0] len_q;
  logic        in_field;

  // offsets 2..5 carry the big-endian total length; shift them in as they pass
  assign in_field = (wptr >= PW'(2)) && (wptr <= PW'(5));
  assign len_next = (wr && in_field) ? {len_q[23:0], wdata} : len_q;

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else     len_q <= len_next;
  end
endmodule

// File: rtl/cmdrsp_stat_word.sv
module cmdrsp_stat_word
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic [7:0]    sts,
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr,
  input  logic [PW-1:0] rlen,
  input  logic          byte_rd,
  output logic [31:0]   word
);
  logic [PW-1:0] avail;
  logic [23:0]   bc;

  always_comb begin
    avail = sts[B_DAV] ? (rlen - rptr) : (PW'(DEPTH) - wptr);
    bc    = 24'(avail);
    if (byte_rd && (bc > 24'd255)) bc = 24'd255;
    word  = {bc, sts};
  end
endmodule

// File: rtl/cmdrsp_buf_ctrl.sv
module cmdrsp_buf_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic          host_byte,
  input  logic [7:0]    host_wdata,
  output logic          host_rvalid,
  output logic [31:0]   host_rdata,
  output logic          exe_start,
  output logic          exe_cancel,
  output logic [PW-1:0] exe_cmd_len,
  input  logic          exe_done,
  input  logic [PW-1:0] exe_resp_len,
  input  logic          exe_selftest,
  input  logic          be_en,
  input  logic          be_we,
  input  logic [AW-1:0] be_addr,
  input  logic [7:0]    be_wdata,
  output logic [7:0]    be_rdata,
  output logic          ev_cmd_ready,
  output logic          ev_data_avail
);
  cbc_state_e    state_q, state_n;
  logic [7:0]    sts_q, sts_n, sts_e, keep;
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n, rlen_q, rlen_n;
  logic          abort_q, abort_n;
  logic          start_n, cancel_n, evc_n, evd_n;
  logic [31:0]   stat_q, word, len_nx;
  logic          sel_q, ff_q;
  logic [7:0]    mem_q;

  logic hw, hr, cmd_rdy, go, retry, fifo_w, fifo_r, store, in_exec, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wd;

  assign hw      = host_req &&  host_we;
  assign hr      = host_req && !host_we;
  assign cmd_rdy = hw && !host_sel && ((host_wdata & ACT_MASK) == ACT_CRDY);
  assign go      = hw && !host_sel && ((host_wdata & ACT_MASK) == ACT_GO);
  assign retry   = hw && !host_sel && ((host_wdata & ACT_MASK) == ACT_RETRY);
  assign fifo_w  = hw &&  host_sel;
  assign fifo_r  = hr &&  host_sel;
  assign in_exec = (state_q == ST_EXEC);
  assign store   = fifo_w && (wptr_q < PW'(DEPTH)) &&
                   ((state_q == ST_READY) || ((state_q == ST_RECEP) && sts_q[B_EXP]));

  // buffer belongs to the backend during execution, to the host otherwise
  assign mem_addr = in_exec ? be_addr : (store ? wptr_q[AW-1:0] : rptr_q[AW-1:0]);
  assign mem_we   = store || (in_exec && be_en && be_we);
  assign mem_wd   = in_exec ? be_wdata : host_wdata;

  cmdrsp_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wd), .rdata(mem_q));

  cmdrsp_len_track #(.PW(PW)) u_len (
    .clk(clk), .rst(rst), .wr(store), .wptr(wptr_q), .wdata(host_wdata),
    .len_next(len_nx));

  cmdrsp_stat_word #(.DEPTH(DEPTH), .PW(PW)) u_stat (
    .sts(sts_q), .wptr(wptr_q), .rptr(rptr_q), .rlen(rlen_q),
    .byte_rd(host_byte), .word(word));

  always_comb begin
    state_n  = state_q;
    sts_n    = sts_q;
    wptr_n   = wptr_q;
    rptr_n   = rptr_q;
    rlen_n   = rlen_q;
    abort_n  = abort_q;
    start_n  = 1'b0;
    cancel_n = 1'b0;
    evc_n    = 1'b0;
    evd_n    = 1'b0;
    keep     = sts_q & (8'h1 << B_STD);
    sts_e    = sts_q;
    if (exe_done && in_exec) begin
      if (exe_selftest) keep[B_STD] = 1'b1;
      rlen_n = exe_resp_len;
      wptr_n = '0;
      rptr_n = '0;
      if (abort_q) begin
        state_n = ST_READY;
        sts_n   = keep | (8'h1 << B_CRDY);
        abort_n = 1'b0;
        evc_n   = 1'b1;
      end else begin
        state_n = ST_COMPL;
        sts_n   = keep | (8'h1 << B_VALID) | (8'h1 << B_DAV);
        evd_n   = 1'b1;
      end
    end else if (cmd_rdy) begin
      unique case (state_q)
        ST_IDLE: begin
          state_n = ST_READY;
          sts_n   = keep | (8'h1 << B_CRDY);
          evc_n   = 1'b1;
        end
        ST_READY: begin
          wptr_n = '0;
          rptr_n = '0;
        end
        ST_RECEP: begin
          wptr_n  = '0;
          rptr_n  = '0;
          state_n = ST_READY;
          sts_n   = keep | (8'h1 << B_CRDY);
          evc_n   = 1'b1;
        end
        ST_EXEC: begin
          if (!abort_q) begin
            abort_n  = 1'b1;
            cancel_n = 1'b1;
          end
        end
        ST_COMPL: begin
          wptr_n  = '0;
          rptr_n  = '0;
          state_n = ST_READY;
          if (sts_q[B_CRDY]) begin
            sts_n = sts_q & ~(8'h1 << B_DAV);
          end else begin
            sts_n = keep | (8'h1 << B_CRDY);
            evc_n = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (go) begin
      if ((state_q == ST_RECEP) && !sts_q[B_EXP]) begin
        state_n = ST_EXEC;
        start_n = 1'b1;
      end
    end else if (retry) begin
      if (state_q == ST_COMPL) begin
        rptr_n = '0;
        sts_n  = keep | (8'h1 << B_VALID) | (8'h1 << B_DAV);
      end
    end else if (fifo_w) begin
      if ((state_q == ST_READY) || (state_q == ST_RECEP)) begin
        if (state_q == ST_READY) begin
          state_n = ST_RECEP;
          sts_e   = keep | (8'h1 << B_EXP) | (8'h1 << B_VALID);
        end
        sts_n = sts_e;
        if (sts_e[B_EXP]) begin
          if (store) begin
            wptr_n = wptr_q + 1'b1;
            if (wptr_n > PW'(5)) begin
              sts_n = keep | (8'h1 << B_VALID);
              if (len_nx > 32'(wptr_n)) sts_n[B_EXP] = 1'b1;
            end
          end else begin
            sts_n = keep | (8'h1 << B_EXP) | (8'h1 << B_VALID);
          end
        end
      end
    end else if (fifo_r) begin
      if ((state_q == ST_COMPL) && sts_q[B_DAV]) begin
        rptr_n = rptr_q + 1'b1;
        if (rptr_n >= rlen_q) sts_n = keep | (8'h1 << B_VALID);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      sts_q         <= '0;
      wptr_q        <= '0;
      rptr_q        <= '0;
      rlen_q        <= '0;
      abort_q       <= 1'b0;
      exe_start     <= 1'b0;
      exe_cancel    <= 1'b0;
      ev_cmd_ready  <= 1'b0;
      ev_data_avail <= 1'b0;
      host_rvalid   <= 1'b0;
      stat_q        <= '0;
      sel_q         <= 1'b0;
      ff_q          <= 1'b1;
    end else begin
      state_q       <= state_n;
      sts_q         <= sts_n;
      wptr_q        <= wptr_n;
      rptr_q        <= rptr_n;
      rlen_q        <= rlen_n;
      abort_q       <= abort_n;
      exe_start     <= start_n;
      exe_cancel    <= cancel_n;
      ev_cmd_ready  <= evc_n;
      ev_data_avail <= evd_n;
      host_rvalid   <= hr;
      sel_q         <= host_sel;
      ff_q          <= !((state_q == ST_COMPL) && sts_q[B_DAV]);
      if (hr && !host_sel) stat_q <= word;
    end
  end

  assign host_rdata  = sel_q ? (ff_q ? 32'h0000_00FF : {24'h0, mem_q}) : stat_q;
  assign exe_cmd_len = wptr_q;
  assign be_rdata    = mem_q;
endmodule

// File: rtl/cmdrsp_buf_checks.sv
module cmdrsp_buf_checks
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          host_req,
  input logic          host_we,
  input logic          host_sel,
  input logic          host_rvalid,
  input logic [31:0]   host_rdata,
  input logic          exe_start,
  input logic          exe_done,
  input cbc_state_e    state,
  input logic [7:0]    sts,
  input logic [PW-1:0] wptr
);
  assert_ff_read_R7: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_sel && state != ST_COMPL)
      |=> (host_rvalid && host_rdata == 32'h0000_00FF));

  assert_go_only_R5: assert property (@(posedge clk) disable iff (rst)
    exe_start |-> (state == ST_EXEC && $past(state) == ST_RECEP && !$past(sts[B_EXP])));

  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    (exe_done && state == ST_EXEC)
      |=> ((state == ST_COMPL && sts[B_DAV] && sts[B_VALID]) ||
           (state == ST_READY && sts[B_CRDY])));

  assert_selftest_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    sts[B_STD] |=> sts[B_STD]);

  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_we && host_sel && !exe_done &&
     (state == ST_IDLE || state == ST_EXEC || state == ST_COMPL))
      |=> $stable(wptr));

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    wptr <= PW'(DEPTH));
endmodule

bind cmdrsp_buf_ctrl cmdrsp_buf_checks #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
  .host_sel(host_sel), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
  .exe_start(exe_start), .exe_done(exe_done), .state(state_q),
  .sts(sts_q), .wptr(wptr_q));

// File: tb/sim_cmdrsp_buf_ctrl.sv
module sim_cmdrsp_buf_ctrl;
  localparam int DEPTH = 300;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 0, host_we = 0, host_sel = 0, host_byte = 0;
  logic [7:0] host_wdata = '0;
  logic host_rvalid;
  logic [31:0] host_rdata;
  logic exe_start, exe_cancel, ev_cmd_ready, ev_data_avail;
  logic [PW-1:0] exe_cmd_len;
  logic exe_done = 0, exe_selftest = 0;
  logic [PW-1:0] exe_resp_len = '0;
  logic be_en = 0, be_we = 0;
  logic [AW-1:0] be_addr = '0;
  logic [7:0] be_wdata = '0, be_rdata;

  always #2 clk = ~clk;

  cmdrsp_buf_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_sel(host_sel), .host_byte(host_byte), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .exe_start(exe_start), .exe_cancel(exe_cancel), .exe_cmd_len(exe_cmd_len),
    .exe_done(exe_done), .exe_resp_len(exe_resp_len), .exe_selftest(exe_selftest),
    .be_en(be_en), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata), .ev_cmd_ready(ev_cmd_ready), .ev_data_avail(ev_data_avail));

  // behavioural reference: 0 idle, 1 ready, 2 receiving, 3 executing, 4 complete
  int m_state, m_sts, m_w, m_r, m_rlen;
  bit m_abort;
  int m_mem [DEPTH];
  bit e_rv, e_start, e_cancel, e_evc, e_evd, e_bev;
  int e_rdata, e_len, e_bed;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_state = 0; m_sts = 0; m_w = 0; m_r = 0; m_rlen = 0; m_abort = 0;
    e_rv = 0; e_start = 0; e_cancel = 0; e_evc = 0; e_evd = 0; e_bev = 0;
    e_rdata = 0; e_len = 0; e_bed = 0;
  endfunction

  function automatic void m_step();
    int keep, v, av;
    longint plen;
    keep = m_sts & 4;
    e_start = 0; e_cancel = 0; e_evc = 0; e_evd = 0;
    e_rv = host_req && !host_we;
    if (e_rv) begin
      if (!host_sel) begin
        av = (m_sts & 16) ? (m_rlen - m_r) : (DEPTH - m_w);
        if (host_byte && av > 255) av = 255;
        e_rdata = (av << 8) | m_sts;
      end else begin
        e_rdata = (m_state == 4 && (m_sts & 16)) ? m_mem[m_r] : 255;
      end
    end
    e_bev = be_en && !be_we && m_state == 3;
    if (e_bev) e_bed = m_mem[be_addr];
    if (be_en && be_we && m_state == 3) m_mem[be_addr] = be_wdata;
    if (exe_done && m_state == 3) begin
      if (exe_selftest) keep = 4;
      m_rlen = exe_resp_len; m_w = 0; m_r = 0;
      if (m_abort) begin m_state = 1; m_sts = keep | 'h40; m_abort = 0; e_evc = 1; end
      else begin m_state = 4; m_sts = keep | 'h90; e_evd = 1; end
    end else if (host_req && host_we && !host_sel) begin
      v = host_wdata & 'h62;
      if (v == 'h40) begin
        case (m_state)
          0: begin m_state = 1; m_sts = keep | 'h40; e_evc = 1; end
          1: begin m_w = 0; m_r = 0; end
          2: begin m_w = 0; m_r = 0; m_state = 1; m_sts = keep | 'h40; e_evc = 1; end
          3: if (!m_abort) begin m_abort = 1; e_cancel = 1; end
          default: begin
            m_w = 0; m_r = 0; m_state = 1;
            if (m_sts & 'h40) m_sts = m_sts & ~'h10;
            else begin m_sts = keep | 'h40; e_evc = 1; end
          end
        endcase
      end else if (v == 'h20) begin
        if (m_state == 2 && !(m_sts & 8)) begin m_state = 3; e_start = 1; end
      end else if (v == 'h02) begin
        if (m_state == 4) begin m_r = 0; m_sts = keep | 'h90; end
      end
    end else if (host_req && host_we && host_sel) begin
      if (m_state == 1) begin m_state = 2; m_sts = keep | 'h88; end
      if (m_state == 2 && (m_sts & 8)) begin
        if (m_w < DEPTH) begin
          m_mem[m_w] = host_wdata;
          m_w++;
          if (m_w > 5) begin
            plen = (longint'(m_mem[2]) << 24) | (longint'(m_mem[3]) << 16) |
                   (longint'(m_mem[4]) << 8) | longint'(m_mem[5]);
            m_sts = keep | 'h80 | ((plen > m_w) ? 8 : 0);
          end
        end else m_sts = keep | 'h88;
      end
    end else if (host_req && !host_we && host_sel) begin
      if (m_state == 4 && (m_sts & 16)) begin
        m_r++;
        if (m_r >= m_rlen) m_sts = keep | 'h80;
      end
    end
    e_len = m_w;
  endfunction

  task automatic cyc();
    m_step();
    @(posedge clk);
    @(negedge clk);
    chk(host_rvalid == e_rv, "rvalid", host_rvalid, e_rv);
    if (e_rv) chk(host_rdata == e_rdata, "rdata", host_rdata, e_rdata);
    chk(exe_start == e_start, "exe_start", exe_start, e_start);
    chk(exe_cancel == e_cancel, "exe_cancel", exe_cancel, e_cancel);
    chk(ev_cmd_ready == e_evc, "ev_cmd_ready", ev_cmd_ready, e_evc);
    chk(ev_data_avail == e_evd, "ev_data_avail", ev_data_avail, e_evd);
    chk(int'(exe_cmd_len) == e_len, "exe_cmd_len", exe_cmd_len, e_len);
    if (e_bev) chk(int'(be_rdata) == e_bed, "be_rdata", be_rdata, e_bed);
    host_req = 0; host_we = 0; host_sel = 0; host_byte = 0; host_wdata = '0;
    be_en = 0; be_we = 0; be_addr = '0; be_wdata = '0;
    exe_done = 0; exe_resp_len = '0; exe_selftest = 0;
  endtask

  task automatic hreg(input bit we, input bit sel, input bit byt, input int d);
    host_req = 1; host_we = we; host_sel = sel; host_byte = byt; host_wdata = 8'(d);
    cyc();
  endtask

  task automatic status_is(input int exp);
    hreg(0, 0, 0, 0);
    chk(host_rdata == 32'(exp), "status", host_rdata, exp);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    m_reset();
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1";  status_is('h00012C00);
    cur_req = "R8";  hreg(0, 0, 1, 0);
    chk(host_rdata == 32'h0000FF00, "byte status", host_rdata, 'hFF00);
    cur_req = "R7";  hreg(0, 1, 0, 0);
    cur_req = "R3";  hreg(1, 1, 0, 'hAA); status_is('h00012C00);
    cur_req = "R13"; hreg(1, 0, 0, 'h60); hreg(1, 0, 0, 'h00); status_is('h00012C00);
    cur_req = "R2";  hreg(1, 0, 0, 'h40); status_is('h00012C40);
    cur_req = "R5";  hreg(1, 0, 0, 'h20); status_is('h00012C40);
    cur_req = "R3";  hreg(1, 1, 0, 'h00); status_is('h00012B88);
    cur_req = "R4";
    hreg(1, 1, 0, 'hC1); hreg(1, 1, 0, 0); hreg(1, 1, 0, 0); hreg(1, 1, 0, 0);
    hreg(1, 1, 0, 'h0A); status_is('h00012688);
    cur_req = "R5";  hreg(1, 0, 0, 'h20);
    cur_req = "R4";
    hreg(1, 1, 0, 'h11); hreg(1, 1, 0, 'h22); hreg(1, 1, 0, 'h33); hreg(1, 1, 0, 'h44);
    status_is('h00012280);
    cur_req = "R3";  hreg(1, 1, 0, 'h55); status_is('h00012280);
    cur_req = "R5";  hreg(1, 0, 0, 'h20);
    chk(exe_cmd_len == PW'(10), "cmd len", exe_cmd_len, 10);
    cur_req = "R3";  hreg(1, 1, 0, 'h77);
    cur_req = "R7";  hreg(0, 1, 0, 0);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) begin be_en = 1; be_addr = AW'(i); cyc(); end
    for (int i = 0; i < 6; i++) begin
      be_en = 1; be_we = 1; be_addr = AW'(i); be_wdata = 8'(8'hA0 + i); cyc();
    end
    cur_req = "R6";  exe_done = 1; exe_resp_len = PW'(6); exe_selftest = 1; cyc();
    status_is('h00000694);
    cur_req = "R7";  hreg(0, 1, 0, 0);
    chk(host_rdata == 32'hA0, "first byte", host_rdata, 'hA0);
    hreg(0, 1, 0, 0); hreg(0, 1, 0, 0);
    cur_req = "R8";  status_is('h00000394);
    cur_req = "R9";  hreg(1, 0, 0, 'h02); status_is('h00000694);
    cur_req = "R7";
    for (int i = 0; i < 6; i++) hreg(0, 1, 0, 0);
    status_is('h00012C84); hreg(0, 1, 0, 0);
    cur_req = "R2";  hreg(1, 0, 0, 'h40);
    cur_req = "R10"; status_is('h00012C44);
    cur_req = "R9";  hreg(1, 0, 0, 'h02); status_is('h00012C44);
    cur_req = "R11";
    hreg(1, 1, 0, 1); hreg(1, 1, 0, 2); hreg(1, 1, 0, 3);
    hreg(1, 0, 0, 'h40); status_is('h00012C44);
    for (int i = 0; i < 5; i++) hreg(1, 1, 0, 0);
    hreg(1, 1, 0, 6); hreg(1, 0, 0, 'h20); hreg(1, 0, 0, 'h40);
    exe_done = 1; exe_resp_len = PW'(4); cyc();
    status_is('h00012C44); hreg(0, 1, 0, 0);
    cur_req = "R2";  hreg(1, 0, 0, 'h40); status_is('h00012C44);
    cur_req = "R12";
    hreg(1, 1, 0, 0); hreg(1, 1, 0, 0); hreg(1, 1, 0, 0); hreg(1, 1, 0, 0);
    hreg(1, 1, 0, 'h10); hreg(1, 1, 0, 0);
    for (int i = 0; i < 299; i++) hreg(1, 1, 0, i);
    status_is('h0000008C); hreg(1, 0, 0, 'h20);
    cur_req = "R10"; do_reset(); status_is('h00012C00);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule